// File: doc/BRIEF.md
# Link Width Fallback Negotiator

This block runs link-width training for a serial port of up to sixteen lanes. When it sees a start pulse, it reads a native-width strap. It then asks an external training engine to try that width. The engine answers with a one-cycle result, either pass or fail. Each failure moves the block one step down the ladder of supported widths: x16, x8, x4, x1. Between two wide attempts the request drops for one cycle. The block drives the lane-enable mask that the physical layer uses during each attempt. A wide link always occupies the contiguous low lanes.

At x1 the block works around a broken lane. It walks lanes 0, 1, 2 and 3 in ascending order and skips any lane whose health flag is low. It reports failure only when no candidate lane is left. A strap code with no supported width fails at once, without any attempt. On success the block holds done, the settled width and the mask until the next start. A start that arrives while training is under way has no effect.

FSM states are IDLE, SCAN, TRIAL, STEP, DONE and FAIL. The transitions are as follows:
- IDLE, DONE or FAIL go to TRIAL on start with a wide strap.
- IDLE, DONE or FAIL go to SCAN on start with the x1 strap.
- IDLE, DONE or FAIL go to FAIL on start with a reserved strap.
- TRIAL goes to DONE on a pass result.
- TRIAL goes to STEP on a failed wide attempt whose next width is still wide.
- TRIAL goes to SCAN on a failed x4 attempt, or on a failed x1 attempt below lane 3.
- TRIAL goes to FAIL on a failed x1 attempt at lane 3.
- STEP always goes to TRIAL.
- SCAN goes to TRIAL when a healthy lane is found, and to FAIL when none is.

Top module: `link_width_negotiator`

## Requirements
- R1: The strap code gives the base-2 log of the width: 0 is x1, 2 is x4, 3 is x8 and 4 is x16. Codes 1, 5, 6 and 7 are reserved. A start with a reserved code raises fail on the next cycle, and trial_req never asserts.
- R2: A start in IDLE, DONE or FAIL always begins again from the native strap width. For a wide strap, trial_req is high on the cycle after start, with trial_width equal to the strap code.
- R3: After a failed wide attempt, the next attempt uses the next narrower supported width (4 to 3 to 2 to 0). Between two wide attempts trial_req stays low for exactly one cycle.
- R4: During a wide attempt, and after a wide success, lane_en bit i is set exactly when i < 2^width. Every other lane is disabled.
- R5: At x1 the lanes are tried in ascending order from 0 to 3, and any lane whose x1_health bit is low is skipped. lane_en has exactly one bit set, at the lane x1_lane selects.
- R6: fail asserts after lane 3 fails at x1, or when no healthy lane is left to try. While fail is high, lane_en is zero.
- R7: From the time trial_req rises until trial_valid arrives, trial_req, trial_width and lane_en stay stable.
- R8: A start while an attempt or scan is in progress is ignored.
- R9: On a pass, done asserts, fail stays low, and final_width and lane_en hold until the next start.
- R10: After reset, trial_req, done and fail are low and lane_en is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| native_code | input | 3 | Native-width strap, log2 encoded |
| start | input | 1 | Begin negotiation pulse |
| x1_health | input | 4 | Health flag per candidate x1 lane |
| trial_valid | input | 1 | One-cycle result strobe from training engine |
| trial_pass | input | 1 | Result of the attempt, qualified by trial_valid |
| trial_req | output | 1 | Attempt in progress, held until result |
| trial_width | output | 3 | Width code under trial or settled |
| lane_en | output | 16 | Lane enable mask |
| x1_lane | output | 2 | Lane chosen for x1 |
| done | output | 1 | Negotiation succeeded |
| fail | output | 1 | Negotiation failed |
| final_width | output | 3 | Negotiated width code while done, else zero |

## Verification
The bench targets four areas: the full ladder from x16 down to x4, the skipping of unhealthy lanes at x1, exhaustion of all four lanes, and reserved straps. A design with a wrong ladder would settle at the wrong width or make the wrong number of attempts. A design that ignored health flags would try a dead lane. Late starts are injected while a long attempt is in progress; a design that does not block them would switch widths in the middle of an attempt. Restarts from DONE and from FAIL check that every run begins again at the native strap width and not at the width left over from the last run.

// File: rtl/lwn_pkg.sv
package lwn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_TRIAL,
        ST_STEP,
        ST_DONE,
        ST_FAIL
    } lwn_state_e;
endpackage

// File: rtl/lwn_strap_decode.sv
// Classifies a width code and names the next narrower supported width.
module lwn_strap_decode #(
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic              supported,
    output logic [CODE_W-1:0] next_code
);
    always_comb begin
        supported = (code == '0) ||
                    ((code >= CODE_W'(2)) && (code <= CODE_W'(MAX_CODE)));
        if (code <= CODE_W'(2)) begin
            next_code = '0;
        end else begin
            next_code = code - CODE_W'(1);
        end
    end
endmodule

// File: rtl/lwn_x1_pick.sv
// Finds the lowest healthy x1 candidate lane at or above a start index.
module lwn_x1_pick #(
    parameter int X1_LANES = 4,
    parameter int IDX_W    = 2
) (
    input  logic [X1_LANES-1:0] health,
    input  logic [IDX_W-1:0]    from,
    output logic                found,
    output logic [IDX_W-1:0]    lane
);
    always_comb begin
        found = 1'b0;
        lane  = '0;
        for (int i = X1_LANES - 1; i >= 0; i--) begin
            if (health[i] && (IDX_W'(i) >= from)) begin
                found = 1'b1;
                lane  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (found) begin
            AST_PICK_HEALTHY: assert (health[lane]); // R5
        end
    end
endmodule

// File: rtl/lwn_lane_mask.sv
// Builds the lane enable mask: contiguous low lanes when wide, one lane at x1.
module lwn_lane_mask #(
    parameter int NLANES   = 16,
    parameter int X1_LANES = 4,
    parameter int CODE_W   = 3,
    parameter int IDX_W    = 2
) (
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic [IDX_W-1:0]  lane,
    output logic [NLANES-1:0] mask
);
    logic [31:0] span;
    assign span = 32'd1 << code;

    for (genvar i = 0; i < NLANES; i++) begin : g_bit
        if (i < X1_LANES) begin : g_cand
            assign mask[i] = en & ((code == '0) ? (lane == IDX_W'(i))
                                                : (32'(i) < span));
        end else begin : g_wide
            assign mask[i] = en & (code != '0) & (32'(i) < span);
        end
    end
endmodule

// File: rtl/link_width_negotiator.sv
module link_width_negotiator
    import lwn_pkg::*;
#(
    parameter int NLANES   = 16,
    parameter int X1_LANES = 4,
    parameter int CODE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] native_code,
    input  logic              start,
    input  logic [X1_LANES-1:0] x1_health,
    input  logic              trial_valid,
    input  logic              trial_pass,
    output logic              trial_req,
    output logic [CODE_W-1:0] trial_width,
    output logic [NLANES-1:0] lane_en,
    output logic [$clog2(X1_LANES)-1:0] x1_lane,
    output logic              done,
    output logic              fail,
    output logic [CODE_W-1:0] final_width
);
    localparam int MAX_CODE = $clog2(NLANES);
    localparam int IDX_W    = $clog2(X1_LANES);
    localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(X1_LANES - 1);

    lwn_state_e         st_q, st_d;
    logic [CODE_W-1:0]  w_q, w_d;
    logic [IDX_W-1:0]   l_q, l_d;

    logic               native_ok;
    logic [CODE_W-1:0]  native_next_unused;
    logic               cur_ok_unused;
    logic [CODE_W-1:0]  step_code;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_lane;
    logic               mask_en;

    lwn_strap_decode #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_native_dec (
        .code      (native_code),
        .supported (native_ok),
        .next_code (native_next_unused)
    );

    lwn_strap_decode #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_step_dec (
        .code      (w_q),
        .supported (cur_ok_unused),
        .next_code (step_code)
    );

    lwn_x1_pick #(.X1_LANES(X1_LANES), .IDX_W(IDX_W)) u_pick (
        .health (x1_health),
        .from   (l_q),
        .found  (pick_found),
        .lane   (pick_lane)
    );

    lwn_lane_mask #(.NLANES(NLANES), .X1_LANES(X1_LANES),
                    .CODE_W(CODE_W), .IDX_W(IDX_W)) u_mask (
        .en   (mask_en),
        .code (w_q),
        .lane (l_q),
        .mask (lane_en)
    );

    // Next-state and datapath decisions
    always_comb begin
        st_d = st_q;
        w_d  = w_q;
        l_d  = l_q;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    l_d = '0;
                    if (!native_ok) begin
                        w_d  = '0;
                        st_d = ST_FAIL;
                    end else begin
                        w_d  = native_code;
                        st_d = (native_code == '0) ? ST_SCAN : ST_TRIAL;
                    end
                end
            end
            ST_SCAN: begin
                if (pick_found) begin
                    l_d  = pick_lane;
                    st_d = ST_TRIAL;
                end else begin
                    st_d = ST_FAIL;
                end
            end
            ST_TRIAL: begin
                if (trial_valid) begin
                    if (trial_pass) begin
                        st_d = ST_DONE;
                    end else if (w_q != '0) begin
                        w_d  = step_code;
                        l_d  = '0;
                        st_d = (step_code == '0) ? ST_SCAN : ST_STEP;
                    end else if (l_q == LAST_LANE) begin
                        st_d = ST_FAIL;
                    end else begin
                        l_d  = l_q + IDX_W'(1);
                        st_d = ST_SCAN;
                    end
                end
            end
            ST_STEP: begin
                st_d = ST_TRIAL;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            w_q  <= '0;
            l_q  <= '0;
        end else begin
            st_q <= st_d;
            w_q  <= w_d;
            l_q  <= l_d;
        end
    end

    // Outputs
    always_comb begin
        trial_req   = (st_q == ST_TRIAL);
        done        = (st_q == ST_DONE);
        fail        = (st_q == ST_FAIL);
        mask_en     = (st_q == ST_TRIAL) || (st_q == ST_DONE);
        trial_width = w_q;
        x1_lane     = l_q;
        final_width = (st_q == ST_DONE) ? w_q : '0;
    end

    AST_HOLD_DURING_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_req && !trial_valid) |=> (trial_req && $stable(trial_width) && $stable(lane_en))); // R7

    AST_LADDER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_req && trial_valid && !trial_pass && (trial_width != '0))
        |=> (trial_width < $past(trial_width))); // R3

    AST_X1_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_req && (trial_width == '0)) |-> ($countones(lane_en) == 1)); // R5

    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> ((lane_en == '0) && !trial_req && !done)); // R6

    AST_RESERVED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && start && !native_ok) |=> (fail && !trial_req)); // R1

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_req && start && !trial_valid) |=> (trial_req && $stable(trial_width))); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && !fail && $stable(final_width) && $stable(lane_en))); // R9
endmodule

// File: tb/sim_link_width_negotiator.sv
module sim_link_width_negotiator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  native_code = 3'd0;
    logic        start = 1'b0;
    logic [3:0]  x1_health = 4'hF;
    logic        trial_valid = 1'b0;
    logic        trial_pass = 1'b0;
    logic        trial_req;
    logic [2:0]  trial_width;
    logic [15:0] lane_en;
    logic [1:0]  x1_lane;
    logic        done;
    logic        fail;
    logic [2:0]  final_width;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int ntrials = 0;
    int lat = 2;
    int tgt_w = 7;
    int tgt_l = 0;
    int cnt = 0;

    // reference model state: 0 idle 1 scan 2 trial 3 step 4 done 5 fail
    int ms = 0;
    int mw = 0;
    int ml = 0;

    always #2.5 clk = ~clk;

    link_width_negotiator u0 (
        .clk(clk), .rst_n(rst_n), .native_code(native_code), .start(start),
        .x1_health(x1_health), .trial_valid(trial_valid), .trial_pass(trial_pass),
        .trial_req(trial_req), .trial_width(trial_width), .lane_en(lane_en),
        .x1_lane(x1_lane), .done(done), .fail(fail), .final_width(final_width)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int emask(input int s, input int w, input int l);
        if (s != 2 && s != 4) return 0;
        if (w == 0) return 1 << l;
        return (1 << (1 << w)) - 1;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mw = 0; ml = 0;
        end else begin
            case (ms)
                0, 4, 5: if (start) begin
                    ml = 0;
                    if (!(native_code == 0 || (native_code >= 2 && native_code <= 4))) begin
                        mw = 0; ms = 5;
                    end else begin
                        mw = native_code;
                        ms = (mw == 0) ? 1 : 2;
                    end
                end
                1: begin
                    int f;
                    f = -1;
                    for (int l = 3; l >= 0; l--) if (x1_health[l] && l >= ml) f = l;
                    if (f >= 0) begin ml = f; ms = 2; end
                    else ms = 5;
                end
                2: if (trial_valid) begin
                    if (trial_pass) ms = 4;
                    else if (mw != 0) begin
                        mw = (mw == 2) ? 0 : mw - 1;
                        ml = 0;
                        ms = (mw == 0) ? 1 : 3;
                    end else if (ml == 3) ms = 5;
                    else begin ml = ml + 1; ms = 1; end
                end
                3: ms = 2;
                default: ms = 0;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(trial_req == (ms == 2), "R7 trial_req", trial_req, ms == 2);
            chk(trial_width == mw, "R3 trial_width", trial_width, mw);
            chk(lane_en == 16'(emask(ms, mw, ml)), "R4 lane_en", lane_en, emask(ms, mw, ml));
            chk(x1_lane == ml, "R5 x1_lane", x1_lane, ml);
            chk(done == (ms == 4), "R9 done", done, ms == 4);
            chk(fail == (ms == 5), "R6 fail", fail, ms == 5);
            chk(final_width == ((ms == 4) ? mw : 0), "R9 final_width", final_width,
                (ms == 4) ? mw : 0);
        end
    end

    // training engine responder
    always @(negedge clk) begin
        if (!rst_n) begin
            trial_valid = 1'b0; cnt = 0;
        end else if (trial_valid) begin
            trial_valid = 1'b0; cnt = 0;
        end else if (trial_req) begin
            cnt++;
            if (cnt >= lat) begin
                trial_valid = 1'b1;
                trial_pass = (trial_width == tgt_w) && (tgt_w != 0 || x1_lane == tgt_l);
                ntrials++;
            end
        end else begin
            cnt = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic go(input int code);
        @(negedge clk);
        native_code = 3'(code);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        while (!(done || fail)) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!trial_req && !done && !fail && lane_en == 0, "R10 reset outputs",
            {trial_req, done, fail}, 0);

        // R2 x16 passes first time
        ntrials = 0; tgt_w = 4; lat = 2;
        go(4);
        chk(trial_req && trial_width == 4, "R2 first attempt native", trial_width, 4);
        wait_end();
        chk(done && final_width == 4, "R2 done at native", final_width, 4);
        chk(lane_en == 16'hFFFF, "R4 x16 mask", lane_en, 16'hFFFF);
        chk(ntrials == 1, "R2 attempt count", ntrials, 1);
        repeat (5) @(negedge clk);
        chk(done && !fail && lane_en == 16'hFFFF, "R9 held after done", lane_en, 16'hFFFF);

        // R3 ladder from x16 to x4
        ntrials = 0; tgt_w = 2;
        go(4);
        wait_end();
        chk(final_width == 2, "R3 settled x4", final_width, 2);
        chk(ntrials == 3, "R3 attempts x16,x8,x4", ntrials, 3);
        chk(lane_en == 16'h000F, "R4 x4 mask", lane_en, 16'h000F);

        // R5 x1 skipping unhealthy lane 1
        ntrials = 0; x1_health = 4'b1101; tgt_w = 0; tgt_l = 3;
        go(3);
        wait_end();
        chk(done && x1_lane == 3, "R5 x1 lane chosen", x1_lane, 3);
        chk(lane_en == 16'h0008, "R5 x1 mask", lane_en, 16'h0008);
        chk(ntrials == 5, "R5 attempts with skip", ntrials, 5);

        // R6 all x1 lanes fail
        ntrials = 0; x1_health = 4'hF; tgt_w = 7;
        go(0);
        wait_end();
        chk(fail && !done, "R6 fail after lanes", fail, 1);
        chk(ntrials == 4, "R6 four x1 attempts", ntrials, 4);
        chk(lane_en == 0, "R6 mask cleared", lane_en, 0);

        // R2 restart from fail at native width
        ntrials = 0; tgt_w = 3;
        go(3);
        wait_end();
        chk(done && final_width == 3 && lane_en == 16'h00FF, "R2 restart from fail",
            lane_en, 16'h00FF);

        // R1 reserved straps
        for (int c = 1; c < 8; c += 4) begin
            ntrials = 0;
            go(c);
            chk(fail && !trial_req, "R1 reserved fails", fail, 1);
            chk(ntrials == 0, "R1 no attempt", ntrials, 0);
        end
        ntrials = 0;
        go(7);
        chk(fail && ntrials == 0, "R1 code 7 reserved", ntrials, 0);

        // R6 no healthy x1 lane
        ntrials = 0; x1_health = 4'h0;
        go(0);
        @(negedge clk);
        chk(fail && ntrials == 0, "R6 no healthy lane", ntrials, 0);
        x1_health = 4'hF;

        // R8 / R7 start ignored during long attempt
        ntrials = 0; tgt_w = 4; lat = 8;
        go(4);
        repeat (2) @(negedge clk);
        native_code = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(trial_req && trial_width == 4, "R8 start ignored", trial_width, 4);
        chk(lane_en == 16'hFFFF, "R7 mask stable", lane_en, 16'hFFFF);
        wait_end();
        chk(done && final_width == 4 && ntrials == 1, "R8 outcome unchanged", final_width, 4);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule